// File: doc/BRIEF.md
# Paced Transmit Payload Generator

This block produces the payload of one transmit stream on a 1024-bit bus. A start pulse latches three settings: a total byte count, a packet byte count and an idle gap. Both byte counts may be up to 48 bits wide. The block splits the total into packets and fills every beat with an incrementing byte pattern. It marks the end of each packet and trims the byte enables of a short final beat. After every packet except the last, it holds its output idle for the programmed gap.

A credit pacer limits the average beat rate to a percentage of the bus bandwidth. The percentage is written through its own strobe, and an invalid value is rejected. The output uses a valid/ready handshake. Status consists of a busy level and a one-cycle done pulse.

The controller has four named states:
- `ST_IDLE` waits for a start pulse.
- `ST_SEND` offers beats when the pacer grants one.
- `ST_GAP` counts down the idle gap.
- `ST_DONE` raises done for one cycle.

The transitions are:
- ST_IDLE→ST_SEND: a start pulse arrives with both byte counts non-zero.
- ST_SEND→ST_GAP: the last beat of a packet is accepted, bytes remain in the transfer, and the gap is non-zero.
- ST_SEND→ST_SEND: the last beat of a packet is accepted, bytes remain, and the gap is zero. Any non-final beat being accepted also keeps the state in ST_SEND.
- ST_SEND→ST_DONE: the final beat of the transfer is accepted.
- ST_GAP→ST_SEND: the gap count expires.
- ST_DONE→ST_IDLE: always, after one cycle.

Top module: `paced_payload_gen`

## Requirements
- R1: After reset, `busy`, `done`, `tx_valid` and `pct_err` are low and the stored percentage is 100.
- R2: A start pulse is accepted only in ST_IDLE, and only when `cfg_total` and `cfg_pkt` are both non-zero. An accepted start latches total, packet size and gap and raises `busy` the next cycle. A start with a zero count is ignored and `busy` stays low.
- R3: Byte lane i of a beat (bits 8i+7..8i) holds (b+i) mod 256. Here b is the number of bytes accepted earlier in the same transfer. The count restarts at 0 for each transfer and runs on across beats and packets.
- R4: Each packet holds min(packet size, bytes left) bytes and uses ceil(bytes/128) beats. `tx_last` is high exactly on the final beat of every packet.
- R5: A beat carrying n bytes has `tx_keep` bits n-1..0 set and the rest clear. Beats that are not the last of a packet carry 128 bytes.
- R6: After the final beat of a packet is accepted, if more bytes remain, `tx_valid` stays low for exactly `cfg_gap` cycles (0 to 255) before pacing resumes.
- R7: The pacer holds a credit below 100. It adds the percentage p once per ST_SEND cycle in which no grant is held or a beat is taken. When the sum reaches 100, it subtracts 100 and grants one beat for the next cycle. With p=100 and ready high, beats are back to back. With p=25, a 40-beat transfer stays busy 161 cycles.
- R8: A write of `cfg_pct` in 1..100 with `cfg_pct_wr` stores it and clears `pct_err`. A write of 0 or above 100 keeps the old percentage and sets `pct_err`.
- R9: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data`, `tx_keep` and `tx_last` hold their values.
- R10: `done` is high for exactly the one cycle after the final beat is accepted, and `busy` falls in that same cycle.
- R11: A start pulse during a running transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| cfg_total | input | 48 | Transfer size in bytes |
| cfg_pkt | input | 48 | Packet size in bytes |
| cfg_gap | input | 8 | Idle cycles after each packet |
| cfg_pct | input | 7 | Rate percentage to store |
| cfg_pct_wr | input | 1 | Write strobe for `cfg_pct` |
| tx_ready | input | 1 | Downstream accepts a beat |
| tx_valid | output | 1 | Beat offered |
| tx_data | output | 1024 | Pattern payload |
| tx_keep | output | 128 | Byte enables, bit i for lane i |
| tx_last | output | 1 | Final beat of a packet |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| pct_err | output | 1 | Last percentage write was rejected |

## Verification
Every output comes from a register, so each result is due one edge after the stimulus that causes it:
- `busy` rises one cycle after an accepted start.
- A pacer grant appears one cycle after the credit sum reaches 100.
- The gap is exactly `cfg_gap` low cycles.
- `done` follows the final handshake by one cycle.
- `pct_err` follows its write strobe by one cycle.

The bench drives inputs a few nanoseconds after each rising edge. It advances a behavioural model on that same edge and compares every output at the falling edge, so model and design are compared in the same cycle. Direct counts of busy cycles and accepted beats cross-check the model.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } ppg_state_e;

    localparam int unsigned PCT_FULL = 100;
endpackage

// File: rtl/ppg_pacer.sv
module ppg_pacer #(
    parameter int PCT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] pct_in,
    input  logic             pct_wr,
    input  logic             clear,
    input  logic             run,
    input  logic             take,
    output logic             grant,
    output logic             pct_bad
);
    localparam int SUM_W = PCT_W + 1;
    localparam logic [SUM_W-1:0] FULL = SUM_W'(ppg_pkg::PCT_FULL);

    logic [PCT_W-1:0] pct_q;
    logic [PCT_W-1:0] credit_q;
    logic [SUM_W-1:0] sum;
    logic             pct_ok;

    assign sum    = {1'b0, credit_q} + {1'b0, pct_q};
    assign pct_ok = (pct_in != '0) && ({1'b0, pct_in} <= FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pct_q   <= PCT_W'(ppg_pkg::PCT_FULL);
            pct_bad <= 1'b0;
        end else if (pct_wr) begin
            if (pct_ok) begin
                pct_q   <= pct_in;
                pct_bad <= 1'b0;
            end else begin
                pct_bad <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            credit_q <= '0;
            grant    <= 1'b0;
        end else if (run && (!grant || take)) begin
            if (sum >= FULL) begin
                credit_q <= PCT_W'(sum - FULL);
                grant    <= 1'b1;
            end else begin
                credit_q <= sum[PCT_W-1:0];
                grant    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ppg_sizer.sv
module ppg_sizer #(
    parameter int SIZE_W = 48,
    parameter int BYTES  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] total_in,
    input  logic [SIZE_W-1:0] pkt_in,
    input  logic              step,
    output logic [$clog2(BYTES+1)-1:0] beat_bytes,
    output logic              pkt_end,
    output logic              xfer_end
);
    localparam int NB_W = $clog2(BYTES + 1);
    localparam logic [SIZE_W-1:0] BEAT = SIZE_W'(BYTES);

    logic [SIZE_W-1:0] tot_q;
    logic [SIZE_W-1:0] pkt_q;
    logic [SIZE_W-1:0] psz_q;
    logic [SIZE_W-1:0] tot_after;

    assign pkt_end    = (pkt_q <= BEAT);
    assign beat_bytes = pkt_end ? pkt_q[NB_W-1:0] : NB_W'(BYTES);
    assign tot_after  = tot_q - SIZE_W'(beat_bytes);
    assign xfer_end   = pkt_end && (tot_after == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_q <= '0;
            pkt_q <= '0;
            psz_q <= '0;
        end else if (load) begin
            tot_q <= total_in;
            psz_q <= pkt_in;
            pkt_q <= (pkt_in < total_in) ? pkt_in : total_in;
        end else if (step) begin
            tot_q <= tot_after;
            if (pkt_end) begin
                pkt_q <= (psz_q < tot_after) ? psz_q : tot_after;
            end else begin
                pkt_q <= pkt_q - BEAT;
            end
        end
    end
endmodule

// File: rtl/ppg_pattern.sv
module ppg_pattern #(
    parameter int BYTES = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step,
    input  logic [$clog2(BYTES+1)-1:0] beat_bytes,
    output logic [BYTES*8-1:0]         data,
    output logic [BYTES-1:0]           keep
);
    localparam int NB_W = $clog2(BYTES + 1);

    logic [7:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            base_q <= '0;
        end else if (step) begin
            base_q <= base_q + 8'(beat_bytes);
        end
    end

    for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
        assign data[lane*8 +: 8] = base_q + 8'(lane);
        assign keep[lane]        = (NB_W'(lane) < beat_bytes);
    end
endmodule

// File: rtl/paced_payload_gen.sv
module paced_payload_gen #(
    parameter int DATA_W = 1024,
    parameter int SIZE_W = 48,
    parameter int GAP_W  = 8,
    parameter int PCT_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SIZE_W-1:0]     cfg_total,
    input  logic [SIZE_W-1:0]     cfg_pkt,
    input  logic [GAP_W-1:0]      cfg_gap,
    input  logic [PCT_W-1:0]      cfg_pct,
    input  logic                  cfg_pct_wr,
    input  logic                  tx_ready,
    output logic                  tx_valid,
    output logic [DATA_W-1:0]     tx_data,
    output logic [DATA_W/8-1:0]   tx_keep,
    output logic                  tx_last,
    output logic                  busy,
    output logic                  done,
    output logic                  pct_err
);
    import ppg_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int NB_W  = $clog2(BYTES + 1);

    ppg_state_e       state_q, state_d;
    logic [GAP_W-1:0] gap_cfg_q;
    logic [GAP_W-1:0] gap_cnt_q;
    logic             accept;
    logic             grant;
    logic             take;
    logic             pkt_end;
    logic             xfer_end;
    logic [NB_W-1:0]  beat_bytes;

    assign accept = (state_q == ST_IDLE) && start && (cfg_total != '0) && (cfg_pkt != '0);
    assign take   = tx_valid && tx_ready;

    ppg_pacer #(.PCT_W(PCT_W)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pct_in  (cfg_pct),
        .pct_wr  (cfg_pct_wr),
        .clear   (accept),
        .run     (state_q == ST_SEND),
        .take    (take),
        .grant   (grant),
        .pct_bad (pct_err)
    );

    ppg_sizer #(.SIZE_W(SIZE_W), .BYTES(BYTES)) u_sizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .total_in   (cfg_total),
        .pkt_in     (cfg_pkt),
        .step       (take),
        .beat_bytes (beat_bytes),
        .pkt_end    (pkt_end),
        .xfer_end   (xfer_end)
    );

    ppg_pattern #(.BYTES(BYTES)) u_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .step       (take),
        .beat_bytes (beat_bytes),
        .data       (tx_data),
        .keep       (tx_keep)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_SEND;
            ST_SEND: begin
                if (take && xfer_end)                          state_d = ST_DONE;
                else if (take && pkt_end && gap_cfg_q != '0)   state_d = ST_GAP;
            end
            ST_GAP:  if (gap_cnt_q == GAP_W'(1)) state_d = ST_SEND;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cfg_q <= '0;
            gap_cnt_q <= '0;
        end else begin
            if (accept) gap_cfg_q <= cfg_gap;
            if (state_q == ST_SEND && state_d == ST_GAP) begin
                gap_cnt_q <= gap_cfg_q;
            end else if (state_q == ST_GAP) begin
                gap_cnt_q <= gap_cnt_q - GAP_W'(1);
            end
        end
    end

    always_comb begin
        tx_valid = (state_q == ST_SEND) && grant;
        tx_last  = pkt_end;
        busy     = (state_q == ST_SEND) || (state_q == ST_GAP);
        done     = (state_q == ST_DONE);
    end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
    parameter int DATA_W = 1024,
    parameter int PCT_W  = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PCT_W-1:0]    cfg_pct,
    input logic                cfg_pct_wr,
    input logic                tx_ready,
    input logic                tx_valid,
    input logic [DATA_W-1:0]   tx_data,
    input logic [DATA_W/8-1:0] tx_keep,
    input logic                tx_last,
    input logic                busy,
    input logic                done,
    input logic                pct_err
);
    p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_last |-> &tx_keep);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_keep) && $stable(tx_last));

    p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tx_valid && tx_ready && tx_last));

    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

    p_bad_pct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pct_wr && (cfg_pct == '0 || cfg_pct > PCT_W'(100)) |=> pct_err);

    p_good_pct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pct_wr && cfg_pct != '0 && cfg_pct <= PCT_W'(100) |=> !pct_err);
endmodule

bind paced_payload_gen ppg_checker #(.DATA_W(DATA_W), .PCT_W(PCT_W)) u_ppg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_pct    (cfg_pct),
    .cfg_pct_wr (cfg_pct_wr),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_keep    (tx_keep),
    .tx_last    (tx_last),
    .busy       (busy),
    .done       (done),
    .pct_err    (pct_err)
);

// File: tb/test_paced_payload_gen.sv
`timescale 1ns/1ps
module test_paced_payload_gen;
    localparam int DW = 1024;
    localparam int NB = DW / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [47:0]     cfg_total = '0;
    logic [47:0]     cfg_pkt = '0;
    logic [7:0]      cfg_gap = '0;
    logic [6:0]      cfg_pct = '0;
    logic            cfg_pct_wr = 1'b0;
    logic            tx_ready = 1'b1;
    logic            tx_valid;
    logic [DW-1:0]   tx_data;
    logic [NB-1:0]   tx_keep;
    logic            tx_last;
    logic            busy;
    logic            done;
    logic            pct_err;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int cyc = 0;
    int beats_seen = 0;
    int busy_cycles = 0;

    // behavioural model
    int      ms = 0;
    longint  m_tot, m_pkt, m_psz;
    int      m_gap, m_gcnt, m_cred, m_pct, m_base;
    bit      m_perm, m_err;

    always #10 clk = ~clk;

    paced_payload_gen i_paced_payload_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_total(cfg_total), .cfg_pkt(cfg_pkt),
        .cfg_gap(cfg_gap), .cfg_pct(cfg_pct), .cfg_pct_wr(cfg_pct_wr), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_keep(tx_keep), .tx_last(tx_last),
        .busy(busy), .done(done), .pct_err(pct_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit take;
        int s, nb;
        cyc++;
        if (!rst_n) begin
            ms = 0; m_pct = 100; m_err = 0; m_cred = 0; m_perm = 0; m_base = 0;
        end else begin
            take = (ms == 1) && m_perm && tx_ready;
            case (ms)
                0: if (start && cfg_total != 0 && cfg_pkt != 0) begin
                    ms = 1; m_tot = cfg_total; m_psz = cfg_pkt;
                    m_pkt = (cfg_pkt < cfg_total) ? cfg_pkt : cfg_total;
                    m_gap = cfg_gap; m_cred = 0; m_perm = 0; m_base = 0;
                end
                1: begin
                    if (!m_perm || take) begin
                        s = m_cred + m_pct;
                        if (s >= 100) begin m_cred = s - 100; m_perm = 1; end
                        else begin m_cred = s; m_perm = 0; end
                    end
                    if (take) begin
                        nb = (m_pkt > NB) ? NB : int'(m_pkt);
                        m_base = (m_base + nb) % 256;
                        m_tot = m_tot - nb;
                        if (m_pkt <= NB) begin
                            if (m_tot == 0) ms = 3;
                            else begin
                                m_pkt = (m_psz < m_tot) ? m_psz : m_tot;
                                if (m_gap != 0) begin ms = 2; m_gcnt = m_gap; end
                            end
                        end else m_pkt = m_pkt - NB;
                    end
                end
                2: if (m_gcnt == 1) ms = 1; else m_gcnt--;
                default: ms = 0;
            endcase
            if (cfg_pct_wr) begin
                if (cfg_pct >= 1 && cfg_pct <= 100) begin m_pct = cfg_pct; m_err = 0; end
                else m_err = 1;
            end
        end
    end

    always @(negedge clk) begin
        bit ev;
        int nb;
        logic [DW-1:0] ed;
        logic [NB-1:0] ek;
        if (rst_n) begin
            ev = (ms == 1) && m_perm;
            check(tx_valid == ev, "R6 R7", "tx_valid", tx_valid, ev);
            check(busy == (ms == 1 || ms == 2), "R2", "busy", busy, (ms == 1 || ms == 2));
            check(done == (ms == 3), "R10", "done", done, (ms == 3));
            check(pct_err == m_err, "R8", "pct_err", pct_err, m_err);
            if (busy) busy_cycles++;
            if (ev && tx_valid) begin
                nb = (m_pkt > NB) ? NB : int'(m_pkt);
                for (int i = 0; i < NB; i++) begin
                    ed[i*8 +: 8] = 8'((m_base + i) % 256);
                    ek[i] = (i < nb);
                end
                check(tx_data == ed, "R3", "tx_data lane0", tx_data[7:0], ed[7:0]);
                check(tx_keep == ek, "R5", "tx_keep ones", $countones(tx_keep), nb);
                check(tx_last == (m_pkt <= NB), "R4", "tx_last", tx_last, (m_pkt <= NB));
                if (tx_ready) beats_seen++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #4;
            tx_ready = (rdy_mode == 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
        end
    end

    initial begin
        @(posedge clk);
        while (cyc < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic set_pct(input int v);
        @(posedge clk); #4; cfg_pct = 7'(v); cfg_pct_wr = 1'b1;
        @(posedge clk); #4; cfg_pct_wr = 1'b0;
    endtask

    task automatic launch(input longint tot, input longint pk, input int gap);
        @(posedge clk); #4;
        cfg_total = 48'(tot); cfg_pkt = 48'(pk); cfg_gap = 8'(gap); start = 1'b1;
        @(posedge clk); #4; start = 1'b0;
    endtask

    task automatic finish_xfer();
        while (ms != 0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #4;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !tx_valid && !pct_err, "R1", "reset outputs",
              {busy, done, tx_valid, pct_err}, 0);
        rst_n = 1'b1;

        // R4 R5 R3: three beats 128,128,44 back to back at full rate
        rdy_mode = 0; beats_seen = 0;
        launch(300, 300, 0); finish_xfer();
        check(beats_seen == 3, "R4", "beat count", beats_seen, 3);

        // R6: five 200-byte packets with a 5-cycle gap
        beats_seen = 0;
        launch(1000, 200, 5); finish_xfer();
        check(beats_seen == 10, "R4", "beat count", beats_seen, 10);

        // R7: 25 percent over 40 full beats
        set_pct(25); busy_cycles = 0;
        launch(40 * 128, 40 * 128, 0); finish_xfer();
        check(busy_cycles == 161, "R7", "busy cycles", busy_cycles, 161);

        // R8: rejected writes keep 25
        set_pct(0);
        @(negedge clk);
        check(pct_err == 1'b1, "R8", "pct_err after 0", pct_err, 1);
        set_pct(101);
        busy_cycles = 0;
        launch(4 * 128, 4 * 128, 0); finish_xfer();
        check(busy_cycles == 17, "R8", "busy cycles with kept pct", busy_cycles, 17);
        set_pct(37);

        // R9: random backpressure with gaps and paced rate
        rdy_mode = 1;
        launch(700, 256, 3); finish_xfer();

        // packet larger than total, slow pace
        set_pct(5);
        launch(128, 1000, 7); finish_xfer();

        // single byte
        set_pct(100); rdy_mode = 0;
        launch(1, 1, 2); finish_xfer();

        // R2: zero sizes ignored
        launch(0, 64, 0);
        @(negedge clk);
        check(busy == 1'b0, "R2", "busy after zero total", busy, 0);
        launch(64, 0, 0);
        @(negedge clk);
        check(busy == 1'b0, "R2", "busy after zero packet", busy, 0);

        // R11: start during a transfer is ignored
        rdy_mode = 1; beats_seen = 0;
        launch(900, 300, 4);
        repeat (3) @(posedge clk);
        launch(5000, 128, 0);
        finish_xfer();
        check(beats_seen == 9, "R11", "beat count", beats_seen, 9);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule